// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards a processor against runaway software. A free-running prescaler divides the CPU clock by one of two power-of-two ratios. Each prescaler tick steps a down-counter that starts at its all-ones value. Software must rewrite the refresh register before the counter passes zero. If the counter does pass zero, the block raises either a one-cycle interrupt request or a latched reset request, depending on a write-once action bit.

A strap-style option input, sampled while reset is held, decides how the block comes out of reset. It either starts counting at once or waits idle until software writes the start register. A low-power mode input freezes both the prescaler and the counter, and counting picks up from the frozen values once the input drops. The bus decoder that turns register writes into the strobes lies outside this block, and so do the interrupt controller and the reset generator that consume the two request outputs.

Top module: `wdt_core`

## Requirements
- R1: While `rst` is high and in the cycle after it, `irq_req` and `reset_req` are 0. Reset clears the prescaler and the divider select to 0, and loads the counter with all ones.
- R2: With `start_on_write` = 0 and divider select 0, the first underflow falls on the DIV_LO × 2^CNT_W-th rising edge after reset is released, counting that edge as number 1. `irq_req` is high for exactly the one cycle that follows that edge.
- R3: After an underflow the counter reloads to all ones and keeps counting, so the next `irq_req` comes exactly one period later.
- R4: A write to `wr_div` with `wr_bit` = 1 selects the ratio DIV_HI; with `wr_bit` = 0 it selects DIV_LO. Both ratios are powers of two, and DIV_LO ≤ DIV_HI. The prescaler ticks on the edges where its low log2(ratio) bits are all ones.
- R5: A `wr_refresh` strobe reloads the counter to all ones and leaves the prescaler phase untouched. The next underflow is therefore the 2^CNT_W-th prescaler tick after the strobe.
- R6: When a refresh falls on the same edge as an underflow tick, the refresh wins and neither request is raised.
- R7: With `start_on_write` = 1 the prescaler and counter stay idle after reset until a `wr_start` strobe. After the strobe, the edge that follows counts as edge number 1 of R2.
- R8: A `wr_start` strobe while the block is already running has no effect on the timing.
- R9: When the action bit is 1, an underflow raises `reset_req` in place of `irq_req`. `reset_req` then stays high until `rst`.
- R10: A `wr_act` strobe with `wr_bit` = 1 sets the action bit. A strobe with `wr_bit` = 0 is ignored, so the bit can never be cleared by software.
- R11: While `sleep` is high, the prescaler and counter hold their values. The period is lengthened by exactly the number of edges spent asleep, and no request is raised while asleep.
- R12: `rst` returns the action bit to 0, so the next underflow gives `irq_req` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| start_on_write | input | 1 | Option: 0 runs straight after reset, 1 waits for a start write |
| sleep | input | 1 | Low-power mode; freezes prescaler and counter |
| wr_refresh | input | 1 | Refresh register write strobe |
| wr_start | input | 1 | Start register write strobe |
| wr_div | input | 1 | Divider select write strobe |
| wr_act | input | 1 | Action bit write strobe |
| wr_bit | input | 1 | Data bit for `wr_div` and `wr_act` |
| irq_req | output | 1 | One-cycle interrupt request on underflow |
| reset_req | output | 1 | Latched reset request on underflow |

## Verification
A refresh write and an underflow tick can land on the same clock edge, and this is the collision that matters. The bench provokes it by placing a refresh strobe exactly on the edge where the counter would pass zero. It then expects no request after that edge and the next interrupt one full period later. A companion scenario refreshes between ticks. That one checks two things: the prescaler phase is kept, and the next underflow falls on a tick boundary computed from the strobe's edge number.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    ACT_IRQ   = 1'b0,
    ACT_RESET = 1'b1
  } wdt_action_e;

  // Clock edges from start to first underflow for a given ratio and width.
  function automatic int unsigned wdt_period(input int unsigned ratio,
                                             input int unsigned cnt_w);
    return ratio * (32'd1 << cnt_w);
  endfunction

  // Mask of prescaler bits that must all be ones for a tick.
  function automatic int unsigned wdt_tick_mask(input int unsigned ratio);
    return ratio - 1;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_hi,
  output logic tick
);
  import wdt_pkg::*;

  localparam int unsigned PW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam logic [PW-1:0] MASK_LO = PW'(wdt_tick_mask(DIV_LO));
  localparam logic [PW-1:0] MASK_HI = PW'(wdt_tick_mask(DIV_HI));

  logic [PW-1:0] pres_q;
  logic [PW-1:0] mask;

  generate
    if (DIV_LO == DIV_HI) begin : g_single
      logic unused_sel;
      assign unused_sel = sel_hi;
      assign mask = MASK_LO;
    end else begin : g_dual
      assign mask = sel_hi ? MASK_HI : MASK_LO;
    end
  endgenerate

  assign tick = en && ((pres_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)     pres_q <= '0;
    else if (en) pres_q <= pres_q + 1'b1;
  end

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int unsigned CNT_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic reload,
  output logic uf
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  assign uf = tick && !reload && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= TOP;
    else if (reload) cnt_q <= TOP;
    else if (tick)   cnt_q <= (cnt_q == '0) ? TOP : cnt_q - 1'b1;
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_on_write,
  input  logic sleep,
  input  logic wr_start,
  input  logic wr_div,
  input  logic wr_act,
  input  logic wr_bit,
  input  logic uf,
  output logic running,
  output logic cnt_en,
  output logic div_hi,
  output logic act_reset,
  output logic irq_req,
  output logic reset_req
);
  import wdt_pkg::*;

  wdt_action_e act_q;

  assign act_reset = (act_q == ACT_RESET);
  assign cnt_en    = running && !sleep;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= !start_on_write;
      div_hi    <= 1'b0;
      act_q     <= ACT_IRQ;
      irq_req   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (wr_start)          running <= 1'b1;
      if (wr_div)            div_hi  <= wr_bit;
      if (wr_act && wr_bit)  act_q   <= ACT_RESET;
      irq_req   <= uf && !act_reset;
      reset_req <= reset_req || (uf && act_reset);
    end
  end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start_on_write,
  input  logic sleep,
  input  logic wr_refresh,
  input  logic wr_start,
  input  logic wr_div,
  input  logic wr_act,
  input  logic wr_bit,
  output logic irq_req,
  output logic reset_req
);

  // Named internal events, observed by the bound checker.
  logic pre_tick;
  logic cnt_uf;
  logic run_q;
  logic act_q;
  logic cnt_en;
  logic div_hi;

  wdt_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .start_on_write (start_on_write),
    .sleep          (sleep),
    .wr_start       (wr_start),
    .wr_div         (wr_div),
    .wr_act         (wr_act),
    .wr_bit         (wr_bit),
    .uf             (cnt_uf),
    .running        (run_q),
    .cnt_en         (cnt_en),
    .div_hi         (div_hi),
    .act_reset      (act_q),
    .irq_req        (irq_req),
    .reset_req      (reset_req)
  );

  wdt_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pres (
    .clk    (clk),
    .rst    (rst),
    .en     (cnt_en),
    .sel_hi (div_hi),
    .tick   (pre_tick)
  );

  wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (pre_tick),
    .reload (wr_refresh),
    .uf     (cnt_uf)
  );

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk (
  input logic clk,
  input logic rst,
  input logic sleep,
  input logic wr_refresh,
  input logic tick,
  input logic uf,
  input logic running,
  input logic act,
  input logic irq,
  input logic rreq
);

  // R11: no prescaler tick while frozen
  a_r11_no_tick_asleep: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !tick);

  // R2: interrupt request lasts one cycle
  a_r2_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R2: interrupt request only follows an underflow
  a_r2_irq_after_uf: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(uf));

  // R6: a refresh strobe suppresses any request on that edge
  a_r6_refresh_wins: assert property (@(posedge clk) disable iff (rst)
    wr_refresh |=> !irq);

  // R8: once running, the block keeps running
  a_r8_run_sticky: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  // R9: reset request holds until reset
  a_r9_rreq_held: assert property (@(posedge clk) disable iff (rst)
    rreq |=> rreq);

  // R9: with action bit set, no interrupt request follows
  a_r9_no_irq_when_act: assert property (@(posedge clk) disable iff (rst)
    act |=> !irq);

  // R10: action bit never clears outside reset
  a_r10_act_sticky: assert property (@(posedge clk) disable iff (rst)
    act |=> act);

endmodule

bind wdt_core wdt_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep      (sleep),
  .wr_refresh (wr_refresh),
  .tick       (pre_tick),
  .uf         (cnt_uf),
  .running    (run_q),
  .act        (act_q),
  .irq        (irq_req),
  .rreq       (reset_req)
);

// File: tb/wdt_core_test.sv
module wdt_core_test;
  localparam int CLK_P = 10;
  localparam int TW    = 6;
  localparam int DLO   = 4;
  localparam int DHI   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_on_write = 1'b0;
  logic sleep = 1'b0;
  logic wr_refresh = 1'b0, wr_start = 1'b0, wr_div = 1'b0, wr_act = 1'b0, wr_bit = 1'b0;
  logic irq_req, reset_req;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt_core #(.CNT_W(TW), .DIV_LO(DLO), .DIV_HI(DHI)) uut (
    .clk(clk), .rst(rst), .start_on_write(start_on_write), .sleep(sleep),
    .wr_refresh(wr_refresh), .wr_start(wr_start), .wr_div(wr_div),
    .wr_act(wr_act), .wr_bit(wr_bit), .irq_req(irq_req), .reset_req(reset_req)
  );

  // Period restated: ratio times counter range.
  function automatic int per(input int ratio);
    return ratio << TW;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic sow);
    @(negedge clk);
    rst = 1'b1; start_on_write = sow; sleep = 1'b0;
    wr_refresh = 0; wr_start = 0; wr_div = 0; wr_act = 0; wr_bit = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_refresh();
    wr_refresh = 1'b1; @(negedge clk); wr_refresh = 1'b0;
  endtask
  task automatic p_start();
    wr_start = 1'b1; @(negedge clk); wr_start = 1'b0;
  endtask
  task automatic p_div(input logic b);
    wr_div = 1'b1; wr_bit = b; @(negedge clk); wr_div = 1'b0; wr_bit = 1'b0;
  endtask
  task automatic p_act(input logic b);
    wr_act = 1'b1; wr_bit = b; @(negedge clk); wr_act = 1'b0; wr_bit = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    chk("R1", "irq after reset", irq_req, 1'b0);
    chk("R1", "reset_req after reset", reset_req, 1'b0);
  endtask

  task automatic t_period_and_wrap();
    do_reset(1'b0);
    adv(per(DLO) - 1);
    chk("R2", "irq before period", irq_req, 1'b0);
    adv(1);
    chk("R2", "irq at period", irq_req, 1'b1);
    adv(1);
    chk("R2", "irq one cycle", irq_req, 1'b0);
    adv(per(DLO) - 2);
    chk("R3", "irq before 2nd period", irq_req, 1'b0);
    adv(1);
    chk("R3", "irq at 2nd period", irq_req, 1'b1);
  endtask

  task automatic t_div_hi();
    do_reset(1'b0);
    p_div(1'b1);
    adv(per(DHI) - 2);
    chk("R4", "irq before high-ratio period", irq_req, 1'b0);
    adv(1);
    chk("R4", "irq at high-ratio period", irq_req, 1'b1);
  endtask

  task automatic t_refresh_mid();
    int k;
    int t_uf;
    do_reset(1'b0);
    k = 102;
    t_uf = ((k / DLO) + (1 << TW)) * DLO;
    adv(k - 1);
    p_refresh();
    adv(t_uf - k - 1);
    chk("R5", "irq just before refreshed underflow", irq_req, 1'b0);
    adv(1);
    chk("R5", "irq at refreshed underflow", irq_req, 1'b1);
  endtask

  task automatic t_refresh_collide();
    do_reset(1'b0);
    adv(per(DLO) - 1);
    p_refresh();
    chk("R6", "irq suppressed by same-edge refresh", irq_req, 1'b0);
    chk("R6", "reset_req suppressed", reset_req, 1'b0);
    adv(per(DLO) - 1);
    chk("R6", "irq before next period", irq_req, 1'b0);
    adv(1);
    chk("R6", "irq one period after collision", irq_req, 1'b1);
  endtask

  task automatic t_manual_start();
    do_reset(1'b1);
    adv(600);
    chk("R7", "idle: no irq", irq_req, 1'b0);
    chk("R7", "idle: no reset_req", reset_req, 1'b0);
    p_start();
    adv(per(DLO) - 1);
    chk("R7", "irq before period after start", irq_req, 1'b0);
    adv(1);
    chk("R7", "irq one period after start", irq_req, 1'b1);
  endtask

  task automatic t_start_while_running();
    do_reset(1'b0);
    adv(9);
    p_start();
    adv(per(DLO) - 11);
    chk("R8", "irq before period", irq_req, 1'b0);
    adv(1);
    chk("R8", "irq timing unchanged by start write", irq_req, 1'b1);
  endtask

  task automatic t_reset_action();
    do_reset(1'b0);
    p_act(1'b1);
    adv(per(DLO) - 2);
    chk("R9", "reset_req before period", reset_req, 1'b0);
    adv(1);
    chk("R9", "reset_req at underflow", reset_req, 1'b1);
    chk("R9", "no irq with reset action", irq_req, 1'b0);
    adv(50);
    chk("R9", "reset_req held", reset_req, 1'b1);
    do_reset(1'b0);
    chk("R12", "reset_req cleared by reset", reset_req, 1'b0);
    adv(per(DLO));
    chk("R12", "irq after reset cleared action bit", irq_req, 1'b1);
    chk("R12", "no reset_req after reset", reset_req, 1'b0);
  endtask

  task automatic t_act_no_clear();
    do_reset(1'b0);
    p_act(1'b1);
    p_act(1'b0);
    adv(per(DLO) - 2);
    chk("R10", "reset_req despite clear attempt", reset_req, 1'b1);
    chk("R10", "no irq despite clear attempt", irq_req, 1'b0);
  endtask

  task automatic t_sleep();
    do_reset(1'b0);
    adv(50);
    sleep = 1'b1; adv(40); sleep = 1'b0;
    adv(per(DLO) - 50 - 1);
    chk("R11", "irq before stretched period", irq_req, 1'b0);
    adv(1);
    chk("R11", "irq at stretched period", irq_req, 1'b1);
    do_reset(1'b0);
    adv(per(DLO) - 6);
    sleep = 1'b1; adv(100);
    chk("R11", "no irq while frozen over underflow point", irq_req, 1'b0);
    sleep = 1'b0;
    adv(5);
    chk("R11", "irq not early after wake", irq_req, 1'b0);
    adv(1);
    chk("R11", "irq resumes from held state", irq_req, 1'b1);
  endtask

  initial begin : main
    t_reset_state();
    t_period_and_wrap();
    t_div_hi();
    t_refresh_mid();
    t_refresh_collide();
    t_manual_start();
    t_start_while_running();
    t_reset_action();
    t_act_no_clear();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule